// File: doc/BRIEF.md
# S/Q Multiframe Channel Handler

This block sits next to an S/T-interface framer and handles the two low-rate maintenance channels carried once per multiframe. In the transmit direction it supplies four Q-channel bits, one each for frames 1, 6, 11 and 16, which the framer places in the FA bit position of those frames. In the receive direction it collects the four S-channel bits that arrive in the same frame positions. It presents them to software only as a complete set from one multiframe.

The framer drives a one-cycle frame strobe, a multiframe-start strobe that comes with the frame strobe of frame 1, a strobe carrying each frame's received FA/S bit, and its multiframe-lock status. A small register port holds the transmit Q bits and an interrupt enable at address 0. Address 1 is a read-only status word: the lock flag, a mirror of the enable, a change flag and the visible S bits. When the enable is set and a newly completed S set differs from the one shown before, the change flag sets and the interrupt output rises. Reading the status word clears the flag.

Top module: `sq_chan_ctrl`

## Requirements
- R1: After reset, address 0 reads 0x0F (Q1..Q4 all 1, enable 0), address 1 reads 0x00 while the lock input is 0, and `irq` is 0.
- R2: A write to address 0 stores bits [4:0]. A read of address 0 returns {3'b000, enable, Q4, Q3, Q2, Q1}, where enable is bit 4 and Q1 is bit 0.
- R3: The frame counter goes to frame 1 on a frame strobe that comes with `mf_start`. It advances by one on every other frame strobe, and it wraps from frame 20 to frame 1 even when `mf_start` is absent.
- R4: In frames 1, 6, 11 and 16, `tx_q_use` is 1 and `tx_q_bit` carries the shadow Q1, Q2, Q3 or Q4 bit respectively. In all other frames `tx_q_use` is 0.
- R5: The shadow Q bits are loaded from address 0 only on a frame strobe that comes with `mf_start`. A write made during a multiframe, or a wrap to frame 1 without `mf_start`, leaves the Q bits of the multiframe in progress unchanged.
- R6: The received bit strobed during frame 1, 6, 11 or 16 becomes S1, S2, S3 or S4, shown in status bits 0, 1, 2 or 3.
- R7: The visible S bits change only on the frame strobe that ends frame 16, and only while `mf_sync` is 1. Bits captured for part of a multiframe never appear.
- R8: At that update the change flag (status bit 5) sets only if the enable is 1 and the new S set differs from the set shown before.
- R9: A read of address 1 returns the change flag as it stood and then clears it. A set event in the same cycle wins over the clear.
- R10: `irq` equals change flag AND enable. Status bit 6 mirrors the enable, and status bit 7 shows `mf_sync` live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | One-cycle strobe at the start of each frame |
| mf_start | input | 1 | With `frm_start`, marks frame 1 of a multiframe |
| rx_bit_vld | input | 1 | Received FA/S bit of the current frame is valid |
| rx_bit | input | 1 | Received FA/S bit value |
| mf_sync | input | 1 | Receiver is locked to the FA/M bit patterns |
| reg_wr | input | 1 | Register write strobe (address 0 only) |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = transmit Q/enable, 1 = receive status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address |
| tx_q_use | output | 1 | Current frame carries a Q bit in its FA position |
| tx_q_bit | output | 1 | Q bit value for the current frame |
| irq | output | 1 | S-channel change interrupt |

## Verification
The bench writes new Q bits in the middle of a multiframe. A design that loaded them right away would send a mix of old and new Q bits within one multiframe. It also lets the frame counter wrap without a multiframe strobe, where a design that reloaded the shadow or failed to wrap would show up at frame 1. On the receive side it feeds S bits while lock is low and reads status halfway through a multiframe. A design without the double buffer, or without the lock gate, would then show partial or unlocked S values. It also repeats an unchanged S set, clears the enable before a change and again while a change is pending, and reads twice in a row. These catch a flag that sets spuriously, ignores the enable, or fails to clear on read.

// File: rtl/sq_chan_ctrl.sv
module sq_chan_ctrl #(
  parameter int MF_LEN   = 20,
  parameter int SLOT_GAP = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_start,
  input  logic       mf_start,
  input  logic       rx_bit_vld,
  input  logic       rx_bit,
  input  logic       mf_sync,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       tx_q_use,
  output logic       tx_q_bit,
  output logic       irq
);
  localparam int NSLOT     = 4;
  localparam int FW        = $clog2(MF_LEN + 1);
  localparam int LAST_SLOT = 1 + SLOT_GAP * (NSLOT - 1);

  logic [FW-1:0] frame_num;
  logic [3:0]    q_reg, q_shadow, s_stage, s_vis;
  logic          en, chg;
  logic          slot_hit;
  logic [1:0]    slot_idx;
  logic          s_update, rd_status;

  always_comb begin
    slot_hit = 1'b0;
    slot_idx = '0;
    for (int k = 0; k < NSLOT; k++)
      if (frame_num == FW'(1 + SLOT_GAP * k)) begin
        slot_hit = 1'b1;
        slot_idx = 2'(k);
      end
  end

  assign s_update  = frm_start && (frame_num == FW'(LAST_SLOT)) && mf_sync;
  assign rd_status = reg_rd && reg_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) frame_num <= '0;
    else if (frm_start) begin
      if (mf_start)                        frame_num <= FW'(1);
      else if (frame_num == FW'(MF_LEN))   frame_num <= FW'(1);
      else if (frame_num != '0)            frame_num <= frame_num + FW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_reg <= 4'hF;
      en    <= 1'b0;
    end else if (reg_wr && !reg_addr) begin
      q_reg <= reg_wdata[3:0];
      en    <= reg_wdata[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q_shadow <= 4'hF;
    else if (frm_start && mf_start) q_shadow <= q_reg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s_stage <= '0;
    else if (rx_bit_vld && slot_hit) s_stage[slot_idx] <= rx_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_vis <= '0;
      chg   <= 1'b0;
    end else begin
      if (s_update) s_vis <= s_stage;
      if (s_update && en && (s_stage != s_vis)) chg <= 1'b1;
      else if (rd_status)                       chg <= 1'b0;
    end
  end

  assign tx_q_use  = slot_hit;
  assign tx_q_bit  = slot_hit & q_shadow[slot_idx];
  assign irq       = chg & en;
  assign reg_rdata = reg_addr ? {mf_sync, en, chg, 1'b0, s_vis}
                              : {3'b000, en, q_reg};
endmodule

// File: rtl/sq_chan_ctrl_chk.sv
module sq_chan_ctrl_chk #(
  parameter int MF_LEN   = 20,
  parameter int SLOT_GAP = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         frm_start,
  input logic                         mf_start,
  input logic                         mf_sync,
  input logic                         reg_rd,
  input logic                         reg_addr,
  input logic                         irq,
  input logic                         en,
  input logic                         chg,
  input logic [3:0]                   s_vis,
  input logic [3:0]                   q_shadow,
  input logic [$clog2(MF_LEN+1)-1:0]  frame_num
);
  localparam int FW        = $clog2(MF_LEN + 1);
  localparam int LAST_SLOT = 1 + SLOT_GAP * 3;

  // R3
  frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_num <= FW'(MF_LEN));

  // R5
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_shadow) |-> $past(frm_start && mf_start));

  // R7
  s_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(s_vis) |-> $past(frm_start && mf_sync && frame_num == FW'(LAST_SLOT)));

  // R8
  chg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg) |-> $past(en && frm_start && mf_sync && frame_num == FW'(LAST_SLOT)));

  // R9
  chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chg) |-> $past(reg_rd && reg_addr));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en && chg));
endmodule

bind sq_chan_ctrl sq_chan_ctrl_chk #(.MF_LEN(MF_LEN), .SLOT_GAP(SLOT_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .mf_start(mf_start),
  .mf_sync(mf_sync), .reg_rd(reg_rd), .reg_addr(reg_addr), .irq(irq),
  .en(en), .chg(chg), .s_vis(s_vis), .q_shadow(q_shadow), .frame_num(frame_num)
);

// File: tb/sq_chan_ctrl_test.sv
module sq_chan_ctrl_test;
  logic       clk = 0, rst_n = 0;
  logic       frm_start = 0, mf_start = 0, rx_bit_vld = 0, rx_bit = 0, mf_sync = 0;
  logic       reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       tx_q_use, tx_q_bit, irq;
  int         n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sq_chan_ctrl uut (.*);

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1; reg_addr = 0; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string req);
    reg_rd = 1; reg_addr = a;
    #1 check(req, reg_rdata, exp);
    @(negedge clk);
    reg_rd = 0; reg_addr = 0;
  endtask

  task automatic run_frames(int first, int last, bit use_mf, logic [3:0] s,
                            bit chk, logic [3:0] expq, int wr_f, logic [7:0] wr_v);
    for (int f = first; f <= last; f++) begin
      bit slot = ((f - 1) % 5 == 0) && (f <= 16);
      int k = (f - 1) / 5;
      frm_start = 1; mf_start = use_mf && (f == 1);
      @(negedge clk);
      frm_start = 0; mf_start = 0;
      if (chk) begin
        check("R4 use", tx_q_use, slot);
        if (slot) check("R4/R5 qbit", tx_q_bit, expq[k]);
      end
      rx_bit_vld = 1; rx_bit = slot ? s[k] : 1'b0;
      @(negedge clk);
      rx_bit_vld = 0;
      if (f == wr_f) wr(wr_v); else @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check("R1 irq", irq, 0);
    check("R1 use", tx_q_use, 0);
    rd(0, 8'h0F, "R1 txreg");
    rd(1, 8'h00, "R1 status");
  endtask

  task automatic t_regrw;
    wr(8'h1A); rd(0, 8'h1A, "R2 readback a");
    wr(8'h09); rd(0, 8'h09, "R2 readback b");
  endtask

  task automatic t_tx;
    run_frames(1, 20, 1, 4'h0, 1, 4'b1001, 3, 8'h06);
    // R3 wrap to frame 1 without mf_start, shadow kept
    run_frames(1, 20, 0, 4'h0, 1, 4'b1001, 0, 8'h00);
    run_frames(1, 20, 1, 4'h0, 1, 4'b0110, 0, 8'h00);
  endtask

  task automatic t_rx;
    wr(8'h16);
    mf_sync = 0;
    run_frames(1, 20, 1, 4'b0101, 0, 4'h0, 0, 8'h00);
    rd(1, 8'h40, "R7 no sync");
    check("R10 irq nosync", irq, 0);
    mf_sync = 1;
    run_frames(1, 20, 1, 4'b0101, 0, 4'h0, 0, 8'h00);
    check("R10 irq set", irq, 1);
    rd(1, 8'hE5, "R6/R8 change");
    rd(1, 8'hC5, "R9 clear");
    check("R9 irq clear", irq, 0);
    run_frames(1, 20, 1, 4'b0101, 0, 4'h0, 0, 8'h00);
    rd(1, 8'hC5, "R8 same value");
    run_frames(1, 10, 1, 4'b1010, 0, 4'h0, 0, 8'h00);
    rd(1, 8'hC5, "R7 partial");
    run_frames(11, 20, 1, 4'b1010, 0, 4'h0, 0, 8'h00);
    rd(1, 8'hEA, "R7 complete");
    rd(1, 8'hCA, "R9 clear2");
  endtask

  task automatic t_enable;
    wr(8'h06);
    run_frames(1, 20, 1, 4'b0011, 0, 4'h0, 0, 8'h00);
    check("R8 en0 irq", irq, 0);
    rd(1, 8'h83, "R8/R10 en0");
    wr(8'h16);
    run_frames(1, 20, 1, 4'b1100, 0, 4'h0, 0, 8'h00);
    check("R10 irq on", irq, 1);
    wr(8'h06);
    check("R10 irq gated", irq, 0);
    rd(1, 8'hAC, "R10 mirror");
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_regrw;
    t_tx;
    t_rx;
    t_enable;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule